// File: doc/BRIEF.md
# Modem-Status Interrupt with Edge-Armed Clear

This block is the clear-to-send (CTS) interrupt section of a serial port. It brings the asynchronous CTS input into the clock domain through a flop chain. It turns every change of the synchronised level into a one-cycle event, and it holds that event in a raw status bit. A mask bit gates the raw bit onto a single interrupt output. Software reads the raw status, the masked status and the current CTS level through a small register bus. It acknowledges the interrupt by writing to a clear address that cannot be read back.

The clear address does not act on the status directly. The write loads a hidden one-bit latch, and the status is cleared only in the cycle after that latch goes from 0 to 1. Hardware returns the latch to 0 once the status reads 0. When a new CTS edge arrives in the same cycle as a clear, the set wins. The latch then stays at 1, and later writes of 1 do nothing. The way out is to write 0 first, which re-arms the latch, and then write 1. The single clock stands for the serial port's own clock, so one cycle is the minimum time the 0 must stay in the latch.

Top module: `mdm_irq_clr`

## Requirements
- R1: After synchronous reset, the raw status, masked status, mask and interrupt output all read 0.
- R2: A rising or a falling edge on `cts_in` sets bit 1 of the raw status register (address 1) within four clock cycles. A CTS level that stays the same sets nothing.
- R3: A write to the clear address (address 4) with bit 1 set clears the raw status only if the hidden latch held 0 in the cycle before. While the latch holds 1, further writes of 1 leave the status set.
- R4: Once the raw status is 0, hardware returns the hidden latch to 0, so the next status can be cleared by a single write of 1.
- R5: When a CTS edge event and a clear event reach the status in the same cycle, the status stays 1 and the latch stays 1.
- R6: Writing 0 to bit 1 of the clear address never clears the status by itself. Writing 1 in the following cycle or later then clears it.
- R7: Reads of the clear address (address 4) return 0 whatever the latch holds.
- R8: Bit 1 of the mask register (address 0, read/write) gates the raw bit. The masked status (address 2, bit 1) equals raw AND mask, and `irq_out` equals the masked bit.
- R9: Bit 0 of address 3 returns the synchronised CTS level, two cycles behind `cts_in`. Unused addresses and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial-port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cts_in | input | 1 | Asynchronous clear-to-send line |
| irq_out | output | 1 | Masked modem interrupt |

## Verification
The bench lines up a CTS edge and a clear write so that both reach the status in the same cycle. A design that let the clear win would drop the status and lose the edge. The bench then writes 1 alone and expects the status to stay set. A design that edge-detected the bus write instead of the latch, or that zeroed the latch without regard to the status, would clear it here. Writing 0 then 1 must recover the status, and a lone write of 0 must not clear it. A design that treats 0 as a clear, or never re-arms, fails one of these two checks. A table of level changes and masks also checks that a steady CTS level sets nothing and that the mask gates only the output.

// File: rtl/mdm_irq_pkg.sv
// Shared constants for the modem-status interrupt block: register
// addresses and the bit position of the CTS interrupt in every status word.
package mdm_irq_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] ADR_MASK   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_RAW    = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MASKED = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_LEVEL  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CLR    = 3'd4;
    localparam int CTS_BIT = 1;
endpackage

// File: rtl/mdm_cts_sync.sv
// Synchronises the asynchronous CTS line through STAGES flops and emits a
// one-cycle event for every change of the synchronised level.
// Assumes STAGES >= 2 and that the line idles low while reset is held.
module mdm_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_async,
    output logic cts_level,
    output logic cts_edge
);
    logic [STAGES-1:0] chain_q;
    logic              level_prev_q;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], cts_async};
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_prev_q <= 1'b0;
        else        level_prev_q <= chain_q[STAGES-1];
    end

    assign cts_level = chain_q[STAGES-1];
    assign cts_edge  = chain_q[STAGES-1] ^ level_prev_q;

    // R2
    edge_follows_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (cts_level != $past(cts_level)) |-> cts_edge);
endmodule

// File: rtl/mdm_clr_latch.sv
// Hidden clear latch. Bus writes load it, and hardware zeroes it while the
// status is 0. Its 0-to-1 transition yields a one-cycle clear pulse.
// Assumes a bus write wins over the hardware zeroing in the same cycle.
module mdm_clr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_bit,
    input  logic status,
    output logic clr_pulse
);
    logic latch_q;
    logic latch_prev_q;

    // Load from the bus, or fall back to 0 once the status is clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= 1'b0;
        else if (wr_stb)  latch_q <= wr_bit;
        else if (!status) latch_q <= 1'b0;
    end

    // Delay copy of the latch for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_prev_q <= 1'b0;
        else        latch_prev_q <= latch_q;
    end

    assign clr_pulse = latch_q & ~latch_prev_q;

    // R4
    latch_rezero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !wr_stb) |=> !latch_q);
    // R3
    steady_one_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !(wr_stb && !wr_bit) && status) |=> !clr_pulse);
endmodule

// File: rtl/mdm_irq_status.sv
// Raw interrupt status bit. A set event wins over a clear event that
// arrives in the same cycle. Assumes both inputs are single-cycle pulses.
module mdm_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic raw
);
    // Hold the status; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       raw <= 1'b0;
        else if (set_evt) raw <= 1'b1;
        else if (clr_evt) raw <= 1'b0;
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> raw);
    // R3
    hold_without_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr_evt) |=> raw);
    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_evt && clr_evt) |=> !raw);
endmodule

// File: rtl/mdm_irq_clr.sv
// Top of the modem-status interrupt block: register decode, mask, read mux,
// and the synchroniser, clear latch and status bit wired together.
// Assumes single-cycle write strobes and a combinational read path.
module mdm_irq_clr
    import mdm_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cts_in,
    output logic              irq_out
);
    logic cts_level, cts_edge, clr_pulse, raw, mask_q, masked;
    logic wr_clr, wr_mask;

    assign wr_clr  = bus_wr && (bus_addr == ADR_CLR);
    assign wr_mask = bus_wr && (bus_addr == ADR_MASK);

    mdm_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cts_async(cts_in),
        .cts_level(cts_level), .cts_edge(cts_edge));

    mdm_clr_latch u_latch (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_clr),
        .wr_bit(bus_wdata[CTS_BIT]), .status(raw), .clr_pulse(clr_pulse));

    mdm_irq_status u_stat (
        .clk(clk), .rst_n(rst_n), .set_evt(cts_edge),
        .clr_evt(clr_pulse), .raw(raw));

    // Mask register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= 1'b0;
        else if (wr_mask) mask_q <= bus_wdata[CTS_BIT];
    end

    assign masked  = raw & mask_q;
    assign irq_out = masked;

    // Read multiplexer; the clear address is write-only.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_MASK:   bus_rdata[CTS_BIT] = mask_q;
            ADR_RAW:    bus_rdata[CTS_BIT] = raw;
            ADR_MASKED: bus_rdata[CTS_BIT] = masked;
            ADR_LEVEL:  bus_rdata[0]       = cts_level;
            default:    bus_rdata          = '0;
        endcase
    end

    // R8
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q |-> !irq_out);
    // R8
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> raw);
    // R7
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_CLR) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_mdm_irq_clr.sv
module tb_mdm_irq_clr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cts_in = 1'b0;
    logic       irq_out;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mdm_irq_clr dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cts_in(cts_in), .irq_out(irq_out));

    // Vector: [4] cts level, [3] mask, [2] do clear, [1] expected raw, [0] expected irq
    localparam logic [4:0] VEC [8] = '{
        5'b11011, 5'b10010, 5'b10100, 5'b00010,
        5'b01011, 5'b01100, 5'b11100, 5'b11000 };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic clr_rearm();   // write 0 then 1 on consecutive cycles
        @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h00;
        @(negedge clk); bus_wdata = 8'h02;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic set_cts(input logic v);
        @(negedge clk); cts_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd1, d); chk("R1 raw", d, 8'h00);
        rd(3'd2, d); chk("R1 masked", d, 8'h00);
        rd(3'd0, d); chk("R1 mask", d, 8'h00);
        chk("R1 irq", {7'd0, irq_out}, 8'h00);

        // Table walk: R2 edges/levels, R8 mask, R6 rearmed clear
        foreach (VEC[i]) begin
            wr(3'd0, {6'd0, VEC[i][3], 1'b0});
            if (cts_in != VEC[i][4]) set_cts(VEC[i][4]);
            else repeat (4) @(negedge clk);
            if (VEC[i][2]) begin clr_rearm(); repeat (2) @(negedge clk); end
            rd(3'd1, d); chk("R2 raw (table)", d, {6'd0, VEC[i][1], 1'b0});
            rd(3'd2, d); chk("R8 masked (table)", d, {6'd0, VEC[i][0], 1'b0});
            chk("R8 irq (table)", {7'd0, irq_out}, {7'd0, VEC[i][0]});
        end

        // R9 level read, cts is 1 after the table
        rd(3'd3, d); chk("R9 level high", d, 8'h01);

        // Race: status set and latch at 0, then edge and clear coincide (R5)
        set_cts(1'b0);
        rd(3'd1, d); chk("R2 falling edge sets", d, 8'h02);
        @(negedge clk); cts_in = 1'b1;
        @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h02;
        @(negedge clk); bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rd(3'd1, d); chk("R5 set wins over clear", d, 8'h02);
        wr(3'd4, 8'h02); repeat (3) @(negedge clk);
        rd(3'd1, d); chk("R3 write 1 while latch stuck", d, 8'h02);
        rd(3'd4, d); chk("R7 clear address reads zero", d, 8'h00);
        wr(3'd4, 8'h00); repeat (3) @(negedge clk);
        rd(3'd1, d); chk("R6 write 0 alone no clear", d, 8'h02);
        wr(3'd4, 8'h02); repeat (2) @(negedge clk);
        rd(3'd1, d); chk("R6 rearmed write 1 clears", d, 8'h00);

        // R4: latch re-zeroed by hardware, single write 1 clears next event
        set_cts(1'b0);
        rd(3'd1, d); chk("R4 new edge sets", d, 8'h02);
        wr(3'd4, 8'h02); repeat (2) @(negedge clk);
        rd(3'd1, d); chk("R4 single write clears", d, 8'h00);
        rd(3'd3, d); chk("R9 level low", d, 8'h00);
        rd(3'd6, d); chk("R9 unused address", d, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule